// File: doc/BRIEF.md
# Interlocked Parallel Port Handshake Controller

This block sits beside an 8-bit parallel port and paces each byte with a two-wire, fully interlocked four-phase handshake. One wire carries an active-low "data available" strobe (/DAV) and the other a "ready" level (RDY). The port's top-bit direction, supplied on `cfg_dir_out`, selects the transfer direction. In input mode the peripheral strobes /DAV and the block answers on RDY. In output mode the block strobes /DAV and the peripheral answers on RDY. The two handshake wires are bound to two fixed auxiliary pins. The pin wired to `hs_in` is always driven by the peripheral, and the pin wired to `hs_out` is always driven by the block. The direction decides whether each pin means /DAV or RDY.

Toward the processor, received bytes leave on a valid/ready stream (`rx_*`) and bytes to send enter on a valid/ready stream (`tx_*`). Back-pressure works as follows. A received byte stays presented, and the peripheral is held off with RDY low, until the byte is taken with `rx_valid && rx_ready`. A byte to send is only accepted (`tx_valid && tx_ready`) when the block is in output mode and idle. While a transfer is running, `tx_ready` stays low. A single-cycle `irq` pulse marks each captured byte and each finished output transfer. The incoming handshake wire passes through a two-flop synchronizer, and the block acts only on its synchronized level.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset the block is in input mode with `port_oe`=0, `hs_out`=1 (RDY high), and `rx_valid`, `tx_ready`, `busy` and `irq` all 0, whatever `cfg_dir_out` reads.
- R2: `cfg_dir_out`=1 selects output mode and 0 selects input mode. A change takes effect (`port_oe` follows it) one clock edge after it is seen while the block is idle. While a received byte is unread, or while an output transfer is busy, the change is deferred.
- R3: In input mode, a falling edge on `hs_in` (/DAV) drives `hs_out` (RDY) low on the third rising clock edge after it. The same edge latches `port_in` into `rx_data` and sets `rx_valid`.
- R4: In input mode, RDY stays low until the byte has been taken and synchronized /DAV is high again. It rises on the edge where both are true: three edges after /DAV rises if the byte was already taken, or on the read edge if /DAV was already high.
- R5: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` stays stable, even if `port_in` changes. The edge with `rx_ready`=1 clears `rx_valid`.
- R6: `tx_ready` is 1 only in output mode while idle. An accepted byte appears on `port_out` at the accepting edge and stays there while `busy`=1.
- R7: In output mode, `hs_out` (/DAV) falls SETUP_CYCLES (default 2) edges after acceptance. If synchronized RDY on `hs_in` is low, the fall waits, and it then comes three edges after RDY rises.
- R8: While /DAV is low, RDY falling on `hs_in` raises /DAV on the third edge. `busy` stays 1 until RDY is high again, and then clears on the third edge after RDY rises, with `tx_ready` returning to 1.
- R9: `irq` is high for exactly one cycle on the edge that captures an input byte and on the edge that ends an output transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir_out | input | 1 | Direction of port top bit: 1 output mode, 0 input mode |
| port_in | input | WIDTH | Data sampled from the port pads |
| port_out | output | WIDTH | Data driven to the port pads in output mode |
| port_oe | output | 1 | 1 while the block is in output mode |
| hs_in | input | 1 | Peripheral-driven handshake pin: /DAV in input mode, RDY in output mode |
| hs_out | output | 1 | Block-driven handshake pin: RDY in input mode, /DAV in output mode |
| tx_valid | input | 1 | Byte to send is offered |
| tx_ready | output | 1 | Block accepts a byte this cycle |
| tx_data | input | WIDTH | Byte to send |
| rx_valid | output | 1 | Received byte is presented |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | WIDTH | Received byte |
| busy | output | 1 | Output transfer in progress |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench sweeps every byte value through both directions. In input mode it alternates between reading the byte before and after /DAV returns high, which catches a design that raises RDY on only one of the two conditions and so lets the peripheral overrun an unread byte. Every handshake response is sampled on the exact edge, so a missing or extra synchronizer stage or a short data setup shows up as an off-by-one. It also stalls output transfers with RDY held low, which a design that starts /DAV without checking RDY would fail. Finally it flips the direction mid-transfer, which a design that does not defer the change would turn around with a transfer still open.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  typedef enum logic [2:0] {
    ST_IN_IDLE   = 3'd0,
    ST_IN_HOLD   = 3'd1,
    ST_OUT_IDLE  = 3'd2,
    ST_OUT_SETUP = 3'd3,
    ST_OUT_DAV   = 3'd4,
    ST_OUT_END   = 3'd5
  } hsp_state_e;

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic level,
  output logic fall
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;
  logic         level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '1;
      level_q <= 1'b1;
    end else begin
      chain   <= {chain[N-2:0], d_in};
      level_q <= chain[N-1];
    end
  end

  assign level = chain[N-1];
  assign fall  = level_q & ~chain[N-1];

endmodule

// File: rtl/hsp_delay.sv
module hsp_delay #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] START = CW'((CYCLES > 0) ? CYCLES - 1 : 0);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= START;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/hsp_rx_buf.sv
module hsp_rx_buf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] cap_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [WIDTH-1:0] rx_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (capture) begin
      rx_valid <= 1'b1;
      rx_data  <= cap_data;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !rx_valid); // R5

endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hsp_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int SETUP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir_out,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic             port_oe,
  input  logic             hs_in,
  output logic             hs_out,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [WIDTH-1:0] tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [WIDTH-1:0] rx_data,
  output logic             busy,
  output logic             irq
);

  hsp_state_e state_q, state_d;
  logic hs_lvl, hs_fall;
  logic capture, accept, out_done, setup_done;
  logic irq_q;
  logic [WIDTH-1:0] out_q;

  hsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(hs_in), .level(hs_lvl), .fall(hs_fall)
  );

  hsp_delay #(.CYCLES(SETUP_CYCLES)) u_setup (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .tick(state_q == ST_OUT_SETUP), .done(setup_done)
  );

  hsp_rx_buf #(.WIDTH(WIDTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_data(port_in),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  assign tx_ready = (state_q == ST_OUT_IDLE) && cfg_dir_out;
  assign accept   = tx_ready && tx_valid;

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    out_done = 1'b0;
    unique case (state_q)
      ST_IN_IDLE: begin
        if (cfg_dir_out) begin
          state_d = ST_OUT_IDLE;
        end else if (hs_fall) begin
          state_d = ST_IN_HOLD;
          capture = 1'b1;
        end
      end
      ST_IN_HOLD: begin
        if ((!rx_valid || rx_ready) && hs_lvl) state_d = ST_IN_IDLE;
      end
      ST_OUT_IDLE: begin
        if (!cfg_dir_out)  state_d = ST_IN_IDLE;
        else if (accept)   state_d = ST_OUT_SETUP;
      end
      ST_OUT_SETUP: begin
        if (setup_done && hs_lvl) state_d = ST_OUT_DAV;
      end
      ST_OUT_DAV: begin
        if (!hs_lvl) state_d = ST_OUT_END;
      end
      ST_OUT_END: begin
        if (hs_lvl) begin
          state_d  = ST_OUT_IDLE;
          out_done = 1'b1;
        end
      end
      default: state_d = ST_IN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IN_IDLE;
      irq_q   <= 1'b0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= capture | out_done;
      if (accept) out_q <= tx_data;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IN_HOLD, ST_OUT_DAV: hs_out = 1'b0;
      default:                hs_out = 1'b1;
    endcase
  end

  assign port_oe  = (state_q == ST_OUT_IDLE) || (state_q == ST_OUT_SETUP) ||
                    (state_q == ST_OUT_DAV)  || (state_q == ST_OUT_END);
  assign busy     = (state_q == ST_OUT_SETUP) || (state_q == ST_OUT_DAV) ||
                    (state_q == ST_OUT_END);
  assign port_out = out_q;
  assign irq      = irq_q;

  AST_RDY_LOW_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_oe && rx_valid |-> !hs_out); // R4
  AST_DIR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> port_oe); // R2
  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(port_out)); // R6
  AST_DAV_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe && $fell(hs_out) |-> $past(hs_lvl)); // R7
  AST_DAV_RISE_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe && $rose(hs_out) |-> !$past(hs_lvl)); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9

endmodule

// File: tb/tb_hs_port_ctrl.sv
module tb_hs_port_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_dir_out = 1'b0;
  logic [W-1:0] port_in = '0;
  logic [W-1:0] port_out;
  logic         port_oe;
  logic         hs_in = 1'b1;
  logic         hs_out;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] tx_data = '0;
  logic         rx_valid;
  logic         rx_ready = 1'b0;
  logic [W-1:0] rx_data;
  logic         busy;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  hs_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2), .SETUP_CYCLES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir_out(cfg_dir_out), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .hs_in(hs_in), .hs_out(hs_out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog R1..all: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic in_xfer(input logic [W-1:0] d, input logic read_first, input logic poke_dir);
    port_in = d;
    hs_in   = 1'b0;
    tick(2);
    chk(hs_out == 1'b1, "R3 rdy high before sync delay", 32'(hs_out), 1);
    tick(1);
    chk(hs_out == 1'b0, "R3 rdy low on third edge", 32'(hs_out), 0);
    chk(rx_valid == 1'b1, "R3 rx_valid set", 32'(rx_valid), 1);
    chk(rx_data == d, "R3 captured byte", 32'(rx_data), 32'(d));
    chk(irq == 1'b1, "R9 irq on capture", 32'(irq), 1);
    port_in = ~d;
    tick(1);
    chk(irq == 1'b0, "R9 irq one cycle", 32'(irq), 0);
    chk(rx_data == d, "R5 rx_data stable", 32'(rx_data), 32'(d));
    if (poke_dir) begin
      cfg_dir_out = 1'b1;
      tick(1);
      chk(port_oe == 1'b0, "R2 direction deferred while unread", 32'(port_oe), 0);
      chk(tx_ready == 1'b0, "R6 no tx accept in input mode", 32'(tx_ready), 0);
      cfg_dir_out = 1'b0;
    end
    if (read_first) begin
      rx_ready = 1'b1;
      tick(1);
      rx_ready = 1'b0;
      chk(rx_valid == 1'b0, "R5 read clears rx_valid", 32'(rx_valid), 0);
      chk(hs_out == 1'b0, "R4 rdy low while dav low", 32'(hs_out), 0);
      hs_in = 1'b1;
      tick(2);
      chk(hs_out == 1'b0, "R4 rdy waits for synced dav", 32'(hs_out), 0);
      tick(1);
      chk(hs_out == 1'b1, "R4 rdy high third edge after dav rise", 32'(hs_out), 1);
    end else begin
      hs_in = 1'b1;
      tick(4);
      chk(hs_out == 1'b0, "R4 rdy low while unread", 32'(hs_out), 0);
      chk(rx_valid == 1'b1, "R5 rx_valid held", 32'(rx_valid), 1);
      chk(rx_data == d, "R5 rx_data held", 32'(rx_data), 32'(d));
      rx_ready = 1'b1;
      tick(1);
      rx_ready = 1'b0;
      chk(rx_valid == 1'b0, "R5 read clears rx_valid", 32'(rx_valid), 0);
      chk(hs_out == 1'b1, "R4 rdy high on read edge", 32'(hs_out), 1);
    end
    tick(1);
  endtask

  task automatic out_xfer(input logic [W-1:0] d, input logic stall, input logic poke_dir);
    if (stall) begin
      hs_in = 1'b0;
      tick(3);
    end
    tx_data  = d;
    tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R6 tx_ready when idle", 32'(tx_ready), 1);
    tick(1);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R6 busy after accept", 32'(busy), 1);
    chk(port_out == d, "R6 byte on port", 32'(port_out), 32'(d));
    chk(tx_ready == 1'b0, "R6 tx_ready low while busy", 32'(tx_ready), 0);
    chk(hs_out == 1'b1, "R7 dav high during setup", 32'(hs_out), 1);
    if (stall) begin
      tick(5);
      chk(hs_out == 1'b1, "R7 dav held while rdy low", 32'(hs_out), 1);
      hs_in = 1'b1;
      tick(2);
      chk(hs_out == 1'b1, "R7 dav waits for synced rdy", 32'(hs_out), 1);
      tick(1);
      chk(hs_out == 1'b0, "R7 dav low third edge after rdy", 32'(hs_out), 0);
    end else begin
      tick(1);
      chk(hs_out == 1'b1, "R7 dav high one edge after accept", 32'(hs_out), 1);
      tick(1);
      chk(hs_out == 1'b0, "R7 dav low after setup", 32'(hs_out), 0);
    end
    hs_in = 1'b0;
    tick(2);
    chk(hs_out == 1'b0, "R8 dav still low", 32'(hs_out), 0);
    tick(1);
    chk(hs_out == 1'b1, "R8 dav rises after rdy low", 32'(hs_out), 1);
    chk(busy == 1'b1, "R8 busy until rdy high", 32'(busy), 1);
    chk(port_out == d, "R6 byte held", 32'(port_out), 32'(d));
    if (poke_dir) begin
      cfg_dir_out = 1'b0;
      tick(1);
      chk(port_oe == 1'b1, "R2 direction deferred while busy", 32'(port_oe), 1);
      cfg_dir_out = 1'b1;
    end
    hs_in = 1'b1;
    tick(2);
    chk(busy == 1'b1, "R8 busy before synced rdy", 32'(busy), 1);
    tick(1);
    chk(busy == 1'b0, "R8 busy clears", 32'(busy), 0);
    chk(irq == 1'b1, "R9 irq on completion", 32'(irq), 1);
    chk(tx_ready == 1'b1, "R8 tx_ready back", 32'(tx_ready), 1);
    tick(1);
    chk(irq == 1'b0, "R9 irq one cycle", 32'(irq), 0);
  endtask

  initial begin
    cfg_dir_out = 1'b1;
    tick(3);
    chk(port_oe == 1'b0, "R1 reset input mode", 32'(port_oe), 0);
    chk(hs_out == 1'b1, "R1 reset rdy high", 32'(hs_out), 1);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", 32'(rx_valid), 0);
    chk(tx_ready == 1'b0, "R1 reset tx_ready", 32'(tx_ready), 0);
    chk(busy == 1'b0, "R1 reset busy", 32'(busy), 0);
    chk(irq == 1'b0, "R1 reset irq", 32'(irq), 0);
    cfg_dir_out = 1'b0;
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < 256; i++) begin
      in_xfer(W'(i), i[0], i[1]);
    end

    cfg_dir_out = 1'b1;
    tick(1);
    chk(port_oe == 1'b1, "R2 switch to output", 32'(port_oe), 1);
    chk(hs_out == 1'b1, "R2 dav idle high", 32'(hs_out), 1);

    for (int i = 0; i < 256; i++) begin
      out_xfer(W'(i), (i % 16) == 3, i[2]);
    end

    cfg_dir_out = 1'b0;
    tick(1);
    chk(port_oe == 1'b0, "R2 switch back to input", 32'(port_oe), 0);
    chk(tx_ready == 1'b0, "R6 tx_ready low in input", 32'(tx_ready), 0);
    in_xfer(8'hA5, 1'b0, 1'b0);
    in_xfer(8'h5A, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule